// File: doc/BRIEF.md
# Upward-Growing Byte Stack Unit

This unit keeps a last-in, first-out stack of bytes in a small internal RAM and tracks its top with a stack pointer. The stack grows toward higher addresses. A push first moves the pointer up by one and writes the byte at that new address in the same cycle. A pop first reads the byte at the current pointer and then moves the pointer down by one. After reset the pointer holds 07h, so the first byte pushed lands at address 08h.

Every stack access moves a single byte. A 16-bit word is handled as two byte accesses in consecutive cycles. For a word push the low byte is written first and the high byte second. For a word pop the high byte is read first and the low byte second, so the word comes back in its original order. The pointer can also be loaded directly, and that load takes priority over any stack access in the same cycle. The pointer wraps modulo 2^SP_W and raises no overflow or underflow indication.

The RAM address, write enable and write data are brought out as ports so the surrounding logic can observe each access. Popped data uses a registered RAM read, so it appears one cycle after the last read of the operation.

Top module: `upstack_unit`

## Requirements
- R1: After reset, sp_o is 07h, busy_o, ram_we_o and pop_valid_o are 0, and the first byte push writes address 08h.
- R2: A byte push (push_i=1, wide_i=0, unit idle, no pointer load) sets ram_we_o=1, ram_addr_o=sp+1 and ram_wdata_o=push_data_i[7:0] in that cycle, and sp_o is sp+1 from the next cycle.
- R3: A byte pop (pop_i=1, push_i=0, wide_i=0, unit idle, no pointer load) reads address sp in that cycle. sp_o is sp-1 from the next cycle. In the next cycle only, pop_valid_o=1 and pop_data_o={8'h00, byte}.
- R4: A word push (wide_i=1) writes push_data_i[7:0] at sp+1 in the request cycle. In the following cycle it writes push_data_i[15:8] at sp+2 with busy_o=1. The pointer ends at sp+2.
- R5: A word pop (wide_i=1) reads the high byte at sp in the request cycle and the low byte at sp-1 in the next cycle, with busy_o=1 during that second cycle. Two cycles after the request, pop_valid_o=1 and pop_data_o={high, low}. The pointer ends at sp-2.
- R6: When sp_wr_i=1, sp_o equals sp_wr_val_i from the next cycle, and no RAM write or read takes place. This holds even if a push, a pop or the second half of a word operation was due in that cycle; that pending second half is dropped.
- R7: The pointer wraps: a push from FFh writes address 00h and leaves sp_o=00h, and a pop from 00h leaves sp_o=FFh.
- R8: When push_i and pop_i are both 1 on an idle cycle, only the push is performed.
- R9: While busy_o=1, push_i, pop_i and wide_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wide_i | input | 1 | 1 selects a two-byte word operation |
| push_data_i | input | 2*DATA_W | Data to push; the byte form uses the low byte |
| sp_wr_i | input | 1 | Direct stack pointer load |
| sp_wr_val_i | input | SP_W | Value for the pointer load |
| sp_o | output | SP_W | Current stack pointer |
| busy_o | output | 1 | Second half of a word operation in progress |
| ram_addr_o | output | SP_W | RAM address: sp+1 on a write, sp otherwise |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | DATA_W | RAM write data |
| pop_valid_o | output | 1 | Popped data valid |
| pop_data_o | output | 2*DATA_W | Popped byte (zero-extended) or word |

## Verification
The RAM write strobe, address and data belong to the cycle in which the push is presented. The second write of a word push follows exactly one cycle later. The pointer shows its new value one cycle after the access. A popped byte is due one cycle after its request, and a popped word two cycles after its request. The bench holds a behavioural model with its own copy of the memory, the pointer and a record of the pending read. On every cycle it drives the inputs, lets the combinational outputs settle, and compares them against the model before the next rising edge. It then advances the model at that edge. As a result each delayed result is checked in exactly the cycle it is due, and any missing or stray pulse is also caught.

// File: rtl/upstack_pkg.sv
package upstack_pkg;

   // sequencing phase of a two-byte operation
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_PUSH_HI = 2'd1,
      PH_POP_LO  = 2'd2
   } phase_e;

   // kind of RAM read issued in the previous cycle
   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_BYTE = 2'd1,
      RK_HI   = 2'd2,
      RK_LO   = 2'd3
   } rdkind_e;

endpackage

// File: rtl/upstack_ram.sv
module upstack_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (re_i) rdata_q <= mem_q[addr_i];
   end

   assign rdata_o = rdata_q;

   // the unit never reads and writes the stack in one cycle (R8)
   assert_no_rw_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && re_i));

endmodule

// File: rtl/upstack_ptr.sv
module upstack_ptr #(
   parameter int SP_W     = 8,
   parameter int RESET_SP = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [SP_W-1:0] load_val_i,
   input  logic            inc_i,
   input  logic            dec_i,
   output logic [SP_W-1:0] sp_o,
   output logic [SP_W-1:0] sp_up_o
);
   localparam logic [SP_W-1:0] SP_RST = SP_W'(RESET_SP);
   localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

   logic [SP_W-1:0] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sp_q <= SP_RST;
      else if (load_i) sp_q <= load_val_i;
      else if (inc_i)  sp_q <= sp_q + SP_ONE;
      else if (dec_i)  sp_q <= sp_q - SP_ONE;
   end

   assign sp_o    = sp_q;
   assign sp_up_o = sp_q + SP_ONE;

   assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> (sp_q == $past(sp_up_o)));

   assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i && !load_i) |=> (sp_q == $past(sp_q) - SP_ONE));

   assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sp_q == $past(load_val_i)));

   assert_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i && !load_i && sp_q == '0) |=> (sp_q == '1));

endmodule

// File: rtl/upstack_seq.sv
module upstack_seq
   import upstack_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_i,
   input  logic                pop_i,
   input  logic                wide_i,
   input  logic [2*DATA_W-1:0] push_data_i,
   input  logic                load_i,
   input  logic [DATA_W-1:0]   rdata_i,
   output logic                inc_o,
   output logic                dec_o,
   output logic                we_o,
   output logic                re_o,
   output logic [DATA_W-1:0]   wdata_o,
   output logic                busy_o,
   output logic                pop_valid_o,
   output logic [2*DATA_W-1:0] pop_data_o
);
   logic wide_eff;

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_eff = wide_i;
      end else begin : g_byte_only
         assign wide_eff = 1'b0;
      end
   endgenerate

   phase_e            ph_q, ph_d;
   rdkind_e           kind_q, kind_d;
   logic [DATA_W-1:0] push_hi_q, push_hi_d;
   logic [DATA_W-1:0] pop_hi_q;

   always_comb begin
      inc_o     = 1'b0;
      dec_o     = 1'b0;
      we_o      = 1'b0;
      re_o      = 1'b0;
      wdata_o   = push_data_i[DATA_W-1:0];
      ph_d      = ph_q;
      kind_d    = RK_NONE;
      push_hi_d = push_hi_q;
      if (load_i) begin
         ph_d = PH_IDLE;
      end else begin
         unique case (ph_q)
            PH_PUSH_HI: begin
               we_o    = 1'b1;
               inc_o   = 1'b1;
               wdata_o = push_hi_q;
               ph_d    = PH_IDLE;
            end
            PH_POP_LO: begin
               re_o   = 1'b1;
               dec_o  = 1'b1;
               kind_d = RK_LO;
               ph_d   = PH_IDLE;
            end
            default: begin
               if (push_i) begin
                  we_o  = 1'b1;
                  inc_o = 1'b1;
                  if (wide_eff) begin
                     ph_d      = PH_PUSH_HI;
                     push_hi_d = push_data_i[2*DATA_W-1:DATA_W];
                  end
               end else if (pop_i) begin
                  re_o  = 1'b1;
                  dec_o = 1'b1;
                  if (wide_eff) begin
                     kind_d = RK_HI;
                     ph_d   = PH_POP_LO;
                  end else begin
                     kind_d = RK_BYTE;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         kind_q    <= RK_NONE;
         push_hi_q <= '0;
         pop_hi_q  <= '0;
      end else begin
         ph_q      <= ph_d;
         kind_q    <= kind_d;
         push_hi_q <= push_hi_d;
         if (kind_q == RK_HI) pop_hi_q <= rdata_i;
      end
   end

   assign busy_o      = (ph_q != PH_IDLE);
   assign pop_valid_o = (kind_q == RK_BYTE) || (kind_q == RK_LO);
   assign pop_data_o  = (kind_q == RK_LO) ? {pop_hi_q, rdata_i}
                                          : {{DATA_W{1'b0}}, rdata_i};

   assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);

   assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid_o |-> $past(re_o));

   assert_push_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !busy_o && !load_i) |-> (we_o && !re_o));

   assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !load_i) |=> !busy_o);

endmodule

// File: rtl/upstack_unit.sv
module upstack_unit #(
   parameter int SP_W     = 8,
   parameter int DATA_W   = 8,
   parameter int RESET_SP = 7,
   parameter bit WIDE_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_i,
   input  logic                pop_i,
   input  logic                wide_i,
   input  logic [2*DATA_W-1:0] push_data_i,
   input  logic                sp_wr_i,
   input  logic [SP_W-1:0]     sp_wr_val_i,
   output logic [SP_W-1:0]     sp_o,
   output logic                busy_o,
   output logic [SP_W-1:0]     ram_addr_o,
   output logic                ram_we_o,
   output logic [DATA_W-1:0]   ram_wdata_o,
   output logic                pop_valid_o,
   output logic [2*DATA_W-1:0] pop_data_o
);
   localparam int DEPTH = 1 << SP_W;

   generate
      if (SP_W < 2 || SP_W > 12) begin : g_bad_sp_w
         $error("upstack_unit: SP_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("upstack_unit: DATA_W must be positive");
      end
      if (RESET_SP < 0 || RESET_SP >= DEPTH) begin : g_bad_reset
         $error("upstack_unit: RESET_SP outside pointer range");
      end
   endgenerate

   logic              inc, dec, we, re;
   logic [SP_W-1:0]   sp, sp_up;
   logic [DATA_W-1:0] wdata, rdata;

   upstack_ptr #(
      .SP_W     (SP_W),
      .RESET_SP (RESET_SP)
   ) ptr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (sp_wr_i),
      .load_val_i (sp_wr_val_i),
      .inc_i      (inc),
      .dec_i      (dec),
      .sp_o       (sp),
      .sp_up_o    (sp_up)
   );

   upstack_seq #(
      .DATA_W  (DATA_W),
      .WIDE_EN (WIDE_EN)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .pop_i       (pop_i),
      .wide_i      (wide_i),
      .push_data_i (push_data_i),
      .load_i      (sp_wr_i),
      .rdata_i     (rdata),
      .inc_o       (inc),
      .dec_o       (dec),
      .we_o        (we),
      .re_o        (re),
      .wdata_o     (wdata),
      .busy_o      (busy_o),
      .pop_valid_o (pop_valid_o),
      .pop_data_o  (pop_data_o)
   );

   assign ram_addr_o  = we ? sp_up : sp;
   assign ram_we_o    = we;
   assign ram_wdata_o = wdata;
   assign sp_o        = sp;

   upstack_ram #(
      .ADDR_W (SP_W),
      .DATA_W (DATA_W)
   ) ram_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .re_i    (re),
      .addr_i  (ram_addr_o),
      .wdata_i (wdata),
      .rdata_o (rdata)
   );

   assert_load_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_i |-> (!ram_we_o && !re));

   assert_write_above_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |=> (sp_o == $past(ram_addr_o)) || $past(sp_wr_i));

endmodule

// File: tb/upstack_unit_tb_top.sv
`timescale 1ns/1ps
module upstack_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 0, pop_i = 0, wide_i = 0, sp_wr_i = 0;
   logic [15:0] push_data_i = '0;
   logic [7:0]  sp_wr_val_i = '0;
   logic [7:0]  sp_o, ram_addr_o, ram_wdata_o;
   logic        busy_o, ram_we_o, pop_valid_o;
   logic [15:0] pop_data_o;

   always #4 clk = ~clk;

   upstack_unit dut_i (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .wide_i(wide_i),
      .push_data_i(push_data_i), .sp_wr_i(sp_wr_i), .sp_wr_val_i(sp_wr_val_i),
      .sp_o(sp_o), .busy_o(busy_o), .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o),
      .ram_wdata_o(ram_wdata_o), .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural model
   logic [7:0] m_mem [256];
   int         m_sp = 7;
   int         m_ph = 0;      // 0 idle, 1 high byte write due, 2 low byte read due
   logic [7:0] m_phi = 0;
   int         m_kind = 0;    // 0 none, 1 byte, 2 high, 3 low
   logic [7:0] m_rd = 0;
   logic [7:0] m_hold = 0;

   task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic cyc(bit p, bit q, bit w, logic [15:0] d, bit l, logic [7:0] lv);
      bit e_we, e_re;
      int e_addr, nk;
      logic [7:0] e_wd, nrd;
      push_i = p; pop_i = q; wide_i = w; push_data_i = d; sp_wr_i = l; sp_wr_val_i = lv;
      #1;
      e_we = 0; e_re = 0; e_addr = m_sp; e_wd = 0; nk = 0;
      if (!l) begin
         if (m_ph == 1) begin
            e_we = 1; e_addr = (m_sp + 1) % 256; e_wd = m_phi;
         end else if (m_ph == 2) begin
            e_re = 1; nk = 3;
         end else if (p) begin
            e_we = 1; e_addr = (m_sp + 1) % 256; e_wd = d[7:0];
         end else if (q) begin
            e_re = 1; nk = w ? 2 : 1;
         end
      end
      chk("sp", {8'h0, sp_o}, 16'(m_sp));
      chk("busy", {15'h0, busy_o}, {15'h0, m_ph != 0});
      chk("we", {15'h0, ram_we_o}, {15'h0, e_we});
      if (e_we) begin
         chk("waddr", {8'h0, ram_addr_o}, 16'(e_addr));
         chk("wdata", {8'h0, ram_wdata_o}, {8'h0, e_wd});
      end
      if (e_re) chk("raddr", {8'h0, ram_addr_o}, 16'(e_addr));
      chk("valid", {15'h0, pop_valid_o}, {15'h0, (m_kind == 1 || m_kind == 3)});
      if (m_kind == 1) chk("pop", pop_data_o, {8'h0, m_rd});
      if (m_kind == 3) chk("pop", pop_data_o, {m_hold, m_rd});
      @(posedge clk);
      nrd = e_re ? m_mem[e_addr] : m_rd;
      if (m_kind == 2) m_hold = m_rd;
      if (e_we) m_mem[e_addr] = e_wd;
      if (l) begin
         m_sp = lv; m_ph = 0;
      end else begin
         if (e_we) m_sp = (m_sp + 1) % 256;
         if (e_re) m_sp = (m_sp + 255) % 256;
         if (m_ph != 0) m_ph = 0;
         else if (p && w) begin m_ph = 1; m_phi = d[15:8]; end
         else if (!p && q && w) m_ph = 2;
      end
      m_kind = nk;
      m_rd = nrd;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0, 0, 8'h0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h0;
      repeat (3) @(negedge clk);
      tag = "R1";
      chk("reset sp", {8'h0, sp_o}, 16'h0007);
      chk("reset valid", {15'h0, pop_valid_o}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      idle(1);
      tag = "R1"; cyc(1, 0, 0, 16'h00A1, 0, 0);          // lands at 08h
      tag = "R2"; cyc(1, 0, 0, 16'h55B2, 0, 0); cyc(1, 0, 0, 16'h00C3, 0, 0);
      tag = "R3"; cyc(0, 1, 0, 16'h0, 0, 0); idle(2);
      tag = "R4"; cyc(1, 0, 1, 16'h1234, 0, 0); idle(1);
      tag = "R5"; cyc(0, 1, 1, 16'h0, 0, 0); idle(3);
      tag = "R8"; cyc(1, 1, 0, 16'h0077, 0, 0); idle(2);
      tag = "R9"; cyc(1, 0, 1, 16'hBEEF, 0, 0); cyc(1, 1, 1, 16'hDEAD, 0, 0); idle(1);
      tag = "R9"; cyc(0, 1, 1, 16'h0, 0, 0); cyc(1, 0, 0, 16'h0099, 0, 0); idle(3);
      tag = "R6"; cyc(1, 0, 0, 16'h0011, 1, 8'h40); cyc(0, 1, 0, 16'h0, 1, 8'h20); idle(2);
      tag = "R6"; cyc(1, 0, 1, 16'hA5C6, 0, 0); cyc(0, 0, 0, 16'h0, 1, 8'h30); idle(2);
      tag = "R6"; cyc(0, 1, 1, 16'h0, 0, 0); cyc(0, 0, 0, 16'h0, 1, 8'h50); idle(3);
      tag = "R7"; cyc(0, 0, 0, 16'h0, 1, 8'hFE); cyc(1, 0, 1, 16'h6789, 0, 0); idle(1);
      tag = "R7";
      for (int i = 0; i < 256; i++) cyc(1, 0, 0, 16'(i * 7 + 3), 0, 0);
      cyc(0, 0, 0, 16'h0, 1, 8'h00); cyc(0, 1, 0, 16'h0, 0, 0); idle(2);
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 15);
         tag = (r < 5) ? "R2" : (r < 10) ? "R3" : (r < 12) ? "R4" : (r < 14) ? "R5" : "R6";
         cyc(r < 5 || r == 10 || r == 11, (r >= 5 && r < 10) || r >= 12,
             r >= 10, 16'($urandom), r == 15, 8'($urandom));
      end
      idle(3);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule